// File: doc/BRIEF.md
# Buffered-Duty PWM Channel

This block is a single 16-bit pulse-width modulator. A counter steps once on each prescaled count strobe. It runs from zero up to one less than the programmed period and then starts again at zero. The main output is high while the count is below the active duty value. Because of this comparison, a duty of zero gives a flat low level and any duty at or above the period gives a flat high level. Both ends of the 0%–100% range are therefore exact.

Software never writes the active duty directly. It writes a staging (buffer) register whenever it likes. The block copies that value into the active duty only when the counter wraps, or when the channel is started. A change therefore takes effect on a whole-period boundary and can never produce a runt pulse. Each wrap also raises a one-cycle interrupt pulse. A mode bit turns on a second output that is the exact inverse of the first, with no dead time between them.

The channel is controlled by a two-state machine. In ST_IDLE the counter is held at zero and both outputs are low. A control write with the run bit set takes the transition START to ST_RUN, and on that edge the buffer is loaded into the active duty. In ST_RUN the counter advances on each strobe. A control write with the run bit clear takes the transition STOP back to ST_IDLE and clears the counter.

Top module: `pwm_duty_channel`

## Requirements
- R1: After synchronous reset the channel is in ST_IDLE with period, buffer and duty all zero and complementary mode off, and pwm_a, pwm_b and irq are all low.
- R2: In ST_RUN the counter advances by one only on clocks where count_en is high. While the channel runs, pwm_a is high exactly when the counter is below the active duty.
- R3: With period P ≥ 1 the counter runs 0 … P-1 and then wraps to 0. A period of 0 behaves like a period of 1, so the counter stays at 0 and every strobe is a wrap.
- R4: A write to the buffer (wr_addr 1) does not change the output until the next wrap. On the wrap edge the buffer value in place before that edge becomes the active duty.
- R5: An active duty of 0 keeps pwm_a low for the whole time the channel runs.
- R6: An active duty at or above the period keeps pwm_a high for the whole time the channel runs.
- R7: irq is high for exactly the one clock that follows each wrap edge, and is low at all other times.
- R8: With complementary mode on (control bit 1) and the channel running, pwm_b is the exact inverse of pwm_a. Otherwise pwm_b is low.
- R9: A control write (wr_addr 2) with bit 0 set moves the channel from ST_IDLE to ST_RUN, loads the buffer into the duty register and starts counting from 0. A control write with bit 0 clear returns the channel to ST_IDLE and clears the counter. In ST_IDLE both outputs are low.
- R10: If the period is written below the current count, the counter wraps on the next strobe.
- R11: A write to wr_addr 3 has no effect on any output or register. The period register is at wr_addr 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Prescaled count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 duty buffer, 2 control, 3 unused |
| wr_data | input | 16 | Write data (control: bit 0 run, bit 1 complementary) |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary PWM output |
| irq | output | 1 | One-cycle pulse per period |

## Verification
All effects are registered. A write or a strobe sampled on one clock edge shows up on pwm_a and pwm_b just after that edge. irq is set by the wrap edge and stays high through the following clock. The bench drives inputs on the falling edge and steps a behavioural model on every rising edge, using the values that were in place before that edge. It then compares all three outputs against the model on each falling edge, so every result is checked in the cycle it is due. Stimulus phases cover the duty extremes, mid-period buffer writes, sparse strobes, periods of 0 and 1, a period shortened below the count, and stop/start, and each phase is tagged with its requirement.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_BUFFER = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_COMP_BIT = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] period_q,
    output logic [W-1:0] buf_q,
    output logic         comp_q,
    output logic         start_p,
    output logic         stop_p
);
    import pwm_pkg::*;

    logic ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign start_p = ctrl_wr && wr_data[CTRL_RUN_BIT];
    assign stop_p  = ctrl_wr && !wr_data[CTRL_RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            buf_q    <= '0;
            comp_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD: period_q <= wr_data;
                ADDR_BUFFER: buf_q    <= wr_data;
                ADDR_CTRL:   comp_q   <= wr_data[CTRL_COMP_BIT];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  logic         start_p,
    input  logic         stop_p,
    input  logic [W-1:0] period_q,
    input  logic [W-1:0] buf_q,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] duty_q,
    output logic         running,
    output logic         load_duty,
    output logic         irq_q
);
    import pwm_pkg::*;

    run_state_e state_q, state_d;
    logic [W-1:0] last_cnt;
    logic         at_end;
    logic         tick;
    logic         wrap;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and decoded outputs
    always_comb begin
        state_d   = state_q;
        tick      = 1'b0;
        load_duty = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_p) begin
                    state_d   = ST_RUN;
                    load_duty = 1'b1;
                end
            end
            ST_RUN: begin
                if (stop_p) state_d = ST_IDLE;
                else        tick    = count_en;
            end
            default: state_d = ST_IDLE;
        endcase
        wrap = tick && at_end;
        if (wrap) load_duty = 1'b1;
    end

    assign last_cnt = (period_q == '0) ? '0 : period_q - 1'b1;
    assign at_end   = (cnt_q >= last_cnt);
    assign running  = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            duty_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= wrap;
            if (load_duty) duty_q <= buf_q;
            if (stop_p || state_q == ST_IDLE) cnt_q <= '0;
            else if (tick)                    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
    parameter int W = 16
) (
    input  logic         running,
    input  logic         comp_q,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] duty_q,
    output logic         pwm_a,
    output logic         pwm_b
);
    logic below;

    assign below = (cnt_q < duty_q);
    assign pwm_a = running && below;
    assign pwm_b = running && comp_q && !below;
endmodule

// File: rtl/pwm_duty_channel.sv
module pwm_duty_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic         irq
);
    logic [W-1:0] period_q, buf_q, cnt_q, duty_q;
    logic         comp_q, start_p, stop_p, running, load_duty;

    pwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period_q (period_q),
        .buf_q    (buf_q),
        .comp_q   (comp_q),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    pwm_timer #(.W(W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .count_en  (count_en),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .period_q  (period_q),
        .buf_q     (buf_q),
        .cnt_q     (cnt_q),
        .duty_q    (duty_q),
        .running   (running),
        .load_duty (load_duty),
        .irq_q     (irq)
    );

    pwm_out #(.W(W)) u_out (
        .running (running),
        .comp_q  (comp_q),
        .cnt_q   (cnt_q),
        .duty_q  (duty_q),
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b)
    );
endmodule

// File: rtl/pwm_duty_channel_chk.sv
module pwm_duty_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         running,
    input logic         comp_q,
    input logic         load_duty,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] duty_q,
    input logic         pwm_a,
    input logic         pwm_b,
    input logic         irq
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!pwm_a && !pwm_b));

    // R5
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (running && duty_q == '0) |-> !pwm_a);

    // R8
    comp_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (running && comp_q) |-> (pwm_b != pwm_a));

    // R7
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt_q == '0));

    // R4
    duty_reload_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_q) |-> $past(load_duty));
endmodule

bind pwm_duty_channel pwm_duty_channel_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .running   (running),
    .comp_q    (comp_q),
    .load_duty (load_duty),
    .cnt_q     (cnt_q),
    .duty_q    (duty_q),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .irq       (irq)
);

// File: tb/pwm_duty_channel_test.sv
module pwm_duty_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        count_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_a, pwm_b, irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    int  m_per = 0, m_buf = 0, m_duty = 0, m_cnt = 0;
    bit  m_run = 0, m_comp = 0, m_irq = 0;

    always #2 clk = ~clk; // 250 MHz

    pwm_duty_channel uut (
        .clk(clk), .rst(rst), .count_en(count_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
    );

    always @(posedge clk) begin
        int  lastc;
        bit  nirq;
        if (rst) begin
            m_per = 0; m_buf = 0; m_duty = 0; m_cnt = 0;
            m_run = 0; m_comp = 0; m_irq = 0;
        end else begin
            nirq  = 0;
            lastc = (m_per == 0) ? 0 : m_per - 1;
            if (!m_run) begin
                if (wr_en && wr_addr == 2 && wr_data[0]) begin
                    m_run = 1; m_duty = m_buf; m_cnt = 0;
                end
            end else if (wr_en && wr_addr == 2 && !wr_data[0]) begin
                m_run = 0; m_cnt = 0;
            end else if (count_en) begin
                if (m_cnt >= lastc) begin
                    m_cnt = 0; m_duty = m_buf; nirq = 1;
                end else m_cnt++;
            end
            m_irq = nirq;
            if (wr_en) begin
                if (wr_addr == 0) m_per = wr_data;
                else if (wr_addr == 1) m_buf = wr_data;
                else if (wr_addr == 2) m_comp = wr_data[1];
            end
        end
    end

    always @(negedge clk) begin
        bit ea, eb;
        if (!rst && !done) begin
            ea = m_run && (m_cnt < m_duty);
            eb = m_run && m_comp && !(m_cnt < m_duty);
            n_cmp++;
            if (pwm_a !== ea || pwm_b !== eb || irq !== m_irq) begin
                n_bad++;
                $display("FAIL %s: a/b/irq actual %b%b%b expected %b%b%b (t=%0t)",
                         cur_req, pwm_a, pwm_b, irq, ea, eb, m_irq, $time);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cycles(input int n, input int strobe_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            count_en = (strobe_every <= 1) ? 1'b1 : ((i % strobe_every) == 0);
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values on outputs
        @(negedge clk);
        n_cmp++;
        if (pwm_a !== 0 || pwm_b !== 0 || irq !== 0) begin
            n_bad++;
            $display("FAIL R1: actual %b%b%b expected 000", pwm_a, pwm_b, irq);
        end
        cur_req = "R11"; wr(2'd3, 16'hFFFF); run_cycles(4, 1);
        cur_req = "R9";  wr(2'd0, 5); wr(2'd1, 2); count_en = 1'b1; wr(2'd2, 1);
        cur_req = "R2";  run_cycles(17, 1);
        cur_req = "R4";  run_cycles(2, 1); wr(2'd1, 4); run_cycles(12, 1);
        cur_req = "R5";  wr(2'd1, 0); run_cycles(15, 1);
        cur_req = "R6";  wr(2'd1, 7); run_cycles(15, 1); wr(2'd1, 5); run_cycles(12, 1);
        cur_req = "R8";  wr(2'd2, 3); wr(2'd1, 3); run_cycles(20, 1);
        cur_req = "R2";  run_cycles(40, 3);
        cur_req = "R7";  run_cycles(30, 2);
        cur_req = "R3";  wr(2'd0, 1); run_cycles(8, 1); wr(2'd0, 0); run_cycles(8, 2);
        cur_req = "R10"; wr(2'd0, 12); wr(2'd1, 6); run_cycles(9, 1);
        wr(2'd0, 3); run_cycles(10, 1);
        cur_req = "R9";  wr(2'd2, 2); run_cycles(8, 1);
        wr(2'd1, 2); wr(2'd2, 1); run_cycles(10, 1);
        cur_req = "R11"; wr(2'd3, 0); run_cycles(10, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule